// File: doc/BRIEF.md
# Quadrature Encoder Timer with Trigger Slave Modes

This block is a general-purpose up/down counter of `CNT_W` bits. A 4-bit mode code decides what moves the counter: the free-running internal clock, one of three quadrature decoders fed by channels A and B, or one of five behaviours controlled by a trigger input. The trigger behaviours are clear, gated, start, external clock, and clear-and-start. The counter wraps against a programmable reload value. It shows its count, a direction flag and a one-cycle update pulse on every wrap or trigger clear.

Channel and trigger pins are asynchronous. Each passes through a two-flop synchroniser, and edges are detected on the synchronised level. An input change therefore reaches the count on the third rising clock edge after it is presented. Mode, enable and reload value are plain parallel inputs from the surrounding logic. The counter only moves while it is running, which means the enable input is high or a trigger start has latched the counter on.

Top module: `qdec_timer`

## Requirements
- R1: During and right after a synchronous active-low reset, count is 0, dir is 0 and update is 0.
- R2: Mode 0 and every unused code (9 to 15) add one per clock while enable is high. The count holds while enable is low.
- R3: Mode 1 steps only on a change of the synchronised B level. The step is up when B's new level equals A's level and down otherwise. Changes of A leave the count untouched.
- R4: Mode 2 steps only on a change of A. The step is up when A's new level differs from B's level and down otherwise. Changes of B leave the count untouched.
- R5: Mode 3 steps on a change of either channel with the same direction rules, giving four counts per quadrature cycle. With A leading B (AB = 00, 10, 11, 01) the count goes up.
- R6: An up step taken while the count is at or above the reload value gives count 0 and a one-cycle update pulse.
- R7: A down step from 0 loads the reload value and gives a one-cycle update pulse.
- R8: After an up step dir is 0. After a down step dir is 1. With no step, dir holds.
- R9: In mode 4 a rising trigger clears the count to 0, sets dir to 0 and pulses update. Between triggers the count runs on the clock while enabled.
- R10: In mode 5 the count adds one per clock only while enabled and the synchronised trigger is high. When the trigger goes low the count holds and is not cleared.
- R11: In mode 6 a rising trigger starts counting even with enable low. A falling trigger does not stop it. Leaving modes 6 and 8 drops the latched start.
- R12: In mode 7 the count adds one per rising trigger edge while enabled, and nothing otherwise.
- R13: In mode 8 a rising trigger clears the count, pulses update and starts counting, with enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| mode_sel | input | 4 | Behaviour code |
| reload_val | input | CNT_W | Wrap limit; the count runs 0..reload_val |
| ch_a | input | 1 | Encoder channel A (asynchronous) |
| ch_b | input | 1 | Encoder channel B (asynchronous) |
| trig_in | input | 1 | Trigger input (asynchronous) |
| count_o | output | CNT_W | Current count |
| dir_o | output | 1 | 0 after an up step, 1 after a down step |
| update_o | output | 1 | One-cycle pulse on wrap or trigger clear |

## Verification
The bench builds the block with `CNT_W` = 8 and the default two synchroniser stages. The narrow counter lets reload values between 4 and 23 put both wrap directions within a few encoder steps of each random walk. It also keeps the directed trigger tests free of accidental wraps when the reload value is 200. Keeping the default stage count means the three-edge latency is the one a full-width build has, so the sample points the bench uses match the production timing.

// File: rtl/qdec_pkg.sv
// Package: mode codes shared by the quadrature encoder timer modules.
// Assumes: codes above QM_CLR_GO are treated as QM_FREE by the control logic.
package qdec_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        QM_FREE     = 4'd0,
        QM_ENC_B    = 4'd1,
        QM_ENC_A    = 4'd2,
        QM_ENC_AB   = 4'd3,
        QM_TRIG_CLR = 4'd4,
        QM_GATE     = 4'd5,
        QM_TRIG_GO  = 4'd6,
        QM_TRIG_CLK = 4'd7,
        QM_CLR_GO   = 4'd8
    } qmode_e;
endpackage

// File: rtl/qdec_sync.sv
// Module: qdec_sync
// Brings W asynchronous bits into the clock domain through STAGES flops, then
// flags every change of the synchronised level against its previous value.
// Assumes: STAGES >= 2; reset is synchronous and active low.
module qdec_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] chg_o
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_q;

    // Shift the raw bits along the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= raw_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    // Keep last cycle's synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stg_q[LAST];
    end

    assign lvl_o = stg_q[LAST];
    assign chg_o = stg_q[LAST] ^ prev_q;

    // R3: a reported change always matches the level held one cycle earlier being different
    a_r3_chg_vs_prev: assert property (@(posedge clk) disable iff (!rst_n)
        |chg_o |=> (prev_q == $past(lvl_o)));
endmodule

// File: rtl/qdec_ctrl.sv
// Module: qdec_ctrl
// Turns the mode code, enable and synchronised inputs into per-cycle step
// requests (up, down, clear) and holds the latched trigger start.
// Assumes: inputs are already synchronised; at most one of up/down is raised.
module qdec_ctrl
    import qdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              en_i,
    input  logic              a_lvl_i,
    input  logic              b_lvl_i,
    input  logic              a_chg_i,
    input  logic              b_chg_i,
    input  logic              t_lvl_i,
    input  logic              t_chg_i,
    output logic              up_o,
    output logic              dn_o,
    output logic              clr_o
);
    logic start_q;
    logic start_mode;
    logic run;
    logic t_rise;
    logic a_up;
    logic b_up;

    assign start_mode = (mode_i == QM_TRIG_GO) || (mode_i == QM_CLR_GO);
    assign run        = en_i || (start_q && start_mode);
    assign t_rise     = t_chg_i && t_lvl_i;
    assign a_up       = (a_lvl_i != b_lvl_i);
    assign b_up       = (b_lvl_i == a_lvl_i);

    // Latch a trigger start while a start-capable mode is selected.
    always_ff @(posedge clk) begin
        if (!rst_n)          start_q <= 1'b0;
        else if (start_mode) start_q <= start_q || t_rise;
        else                 start_q <= 1'b0;
    end

    // Decode one step request per cycle from the selected behaviour.
    always_comb begin
        up_o  = 1'b0;
        dn_o  = 1'b0;
        clr_o = 1'b0;
        case (mode_i)
            QM_ENC_B: begin
                if (run && b_chg_i) begin
                    up_o = b_up;
                    dn_o = !b_up;
                end
            end
            QM_ENC_A: begin
                if (run && a_chg_i) begin
                    up_o = a_up;
                    dn_o = !a_up;
                end
            end
            QM_ENC_AB: begin
                if (run && (a_chg_i ^ b_chg_i)) begin
                    up_o = a_chg_i ? a_up : b_up;
                    dn_o = !up_o;
                end
            end
            QM_TRIG_CLR, QM_CLR_GO: begin
                clr_o = t_rise;
                up_o  = run && !t_rise;
            end
            QM_GATE:     up_o = run && t_lvl_i;
            QM_TRIG_GO:  up_o = run;
            QM_TRIG_CLK: up_o = run && t_rise;
            default:     up_o = run;
        endcase
    end

    // R8: up and down are never requested together
    a_r8_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_o && dn_o));

    // R11: a latched start survives while a start mode stays selected
    a_r11_start_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && start_mode) |=> start_q);

    // R10: gated mode never steps while the trigger is low
    a_r10_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == QM_GATE && !t_lvl_i) |-> !(up_o || dn_o));

    // R5: encoder modes step only on a channel change
    a_r5_enc_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == QM_ENC_A || mode_i == QM_ENC_B || mode_i == QM_ENC_AB)
         && !a_chg_i && !b_chg_i) |-> !(up_o || dn_o));
endmodule

// File: rtl/qdec_counter.sv
// Module: qdec_counter
// Count register with wrap against the reload value, direction flag and a
// one-cycle update pulse on wraps and clears. Clear beats up beats down.
// Assumes: step requests are single-cycle decisions from qdec_ctrl.
module qdec_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             upd_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Apply the step request, wrapping at the reload value or zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
            dir_o <= 1'b0;
            upd_o <= 1'b0;
        end else begin
            upd_o <= 1'b0;
            if (clr_i) begin
                cnt_o <= '0;
                dir_o <= 1'b0;
                upd_o <= 1'b1;
            end else if (up_i) begin
                dir_o <= 1'b0;
                if (cnt_o >= reload_i) begin
                    cnt_o <= '0;
                    upd_o <= 1'b1;
                end else begin
                    cnt_o <= cnt_o + ONE;
                end
            end else if (dn_i) begin
                dir_o <= 1'b1;
                if (cnt_o == '0) begin
                    cnt_o <= reload_i;
                    upd_o <= 1'b1;
                end else begin
                    cnt_o <= cnt_o - ONE;
                end
            end
        end
    end

    // R6: an up step at or above the limit lands on zero with an update
    a_r6_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && !clr_i && cnt_o >= reload_i) |=> (cnt_o == '0 && upd_o));

    // R7: a down step from zero lands on the reload value with an update
    a_r7_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_i && !up_i && !clr_i && cnt_o == '0) |=> (cnt_o == $past(reload_i) && upd_o));

    // R8: direction follows the last step taken
    a_r8_dir_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_i && !up_i && !clr_i) |=> dir_o);

    // R2: without a request nothing moves and no update appears
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_i || dn_i || clr_i) |=> ($stable(cnt_o) && $stable(dir_o) && !upd_o));
endmodule

// File: rtl/qdec_timer.sv
// Module: qdec_timer (top)
// Quadrature encoder / trigger-slave counter: synchronises the channel and
// trigger pins, decodes the mode into step requests and drives the counter.
// Assumes: mode, enable and reload are already in the clock domain.
module qdec_timer
    import qdec_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [3:0]       mode_sel,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             ch_a,
    input  logic             ch_b,
    input  logic             trig_in,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_o,
    output logic             update_o
);
    localparam int PIN_N = 3;
    localparam int PA    = 0;
    localparam int PB    = 1;
    localparam int PT    = 2;

    logic [PIN_N-1:0] pin_lvl;
    logic [PIN_N-1:0] pin_chg;
    logic             step_up;
    logic             step_dn;
    logic             step_clr;

    qdec_sync #(
        .W      (PIN_N),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({trig_in, ch_b, ch_a}),
        .lvl_o (pin_lvl),
        .chg_o (pin_chg)
    );

    qdec_ctrl i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_sel),
        .en_i    (cnt_en),
        .a_lvl_i (pin_lvl[PA]),
        .b_lvl_i (pin_lvl[PB]),
        .a_chg_i (pin_chg[PA]),
        .b_chg_i (pin_chg[PB]),
        .t_lvl_i (pin_lvl[PT]),
        .t_chg_i (pin_chg[PT]),
        .up_o    (step_up),
        .dn_o    (step_dn),
        .clr_o   (step_clr)
    );

    qdec_counter #(
        .CNT_W (CNT_W)
    ) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_i     (step_up),
        .dn_i     (step_dn),
        .clr_i    (step_clr),
        .reload_i (reload_val),
        .cnt_o    (count_o),
        .dir_o    (dir_o),
        .upd_o    (update_o)
    );

    // R1: the cycle after reset is released the outputs sit at their idle values
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && !dir_o && !update_o));

    // R9: a clear request in mode 4 gives zero count, up direction and an update
    a_r9_trig_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == QM_TRIG_CLR && step_clr) |=> (count_o == '0 && !dir_o && update_o));

    // R12: external-clock mode steps only on a rising trigger
    a_r12_ext_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == QM_TRIG_CLK && !(pin_chg[PT] && pin_lvl[PT])) |-> !step_up);
endmodule

// File: tb/test_qdec_timer.sv
module test_qdec_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int WATCHDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_en = 1'b0;
    logic [3:0]       mode_sel = 4'd0;
    logic [CNT_W-1:0] reload_val = 8'd200;
    logic             ch_a = 1'b0;
    logic             ch_b = 1'b0;
    logic             trig_in = 1'b0;
    logic [CNT_W-1:0] count_o;
    logic             dir_o;
    logic             update_o;

    int total = 0;
    int bad = 0;
    int upd_seen = 0;
    int upd_exp = 0;
    int e_cnt = 0;
    int e_dir = 0;
    int phase = 0;
    int cyc = 0;
    bit done = 1'b0;

    qdec_timer #(.CNT_W(CNT_W)) i_qdec_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .mode_sel   (mode_sel),
        .reload_val (reload_val),
        .ch_a       (ch_a),
        .ch_b       (ch_b),
        .trig_in    (trig_in),
        .count_o    (count_o),
        .dir_o      (dir_o),
        .update_o   (update_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count update pulses away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && update_o) upd_seen++;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int nxt_up(input int c, input int rl);
        return (c >= rl) ? 0 : c + 1;
    endfunction

    function automatic int nxt_dn(input int c, input int rl);
        return (c == 0) ? rl : c - 1;
    endfunction

    // Phase to levels: 0=00 1=10 2=11 3=01 (A leads B when going forward).
    function automatic bit ph_a(input int p);
        return (p == 1) || (p == 2);
    endfunction

    function automatic bit ph_b(input int p);
        return (p == 2) || (p == 3);
    endfunction

    // Clear the count through a mode-4 trigger with enable low.
    task automatic clear_cnt();
        cnt_en = 1'b0;
        mode_sel = 4'd4;
        trig_in = 1'b0;
        tick(4);
        trig_in = 1'b1;
        tick(5);
        trig_in = 1'b0;
        tick(4);
        e_cnt = 0;
        e_dir = 0;
        upd_exp++;
    endtask

    // One quadrature step; model decides whether the active mode counts it.
    task automatic enc_step(input bit fwd, input int md, input int rl, input string req);
        int np;
        bit a_ch;
        bit counts;
        np = fwd ? (phase + 1) % 4 : (phase + 3) % 4;
        a_ch = (ph_a(np) != ph_a(phase));
        phase = np;
        ch_a = ph_a(np);
        ch_b = ph_b(np);
        counts = (md == 3) || (md == 2 && a_ch) || (md == 1 && !a_ch);
        if (counts) begin
            if (fwd) begin
                if (e_cnt >= rl) upd_exp++;
                e_cnt = nxt_up(e_cnt, rl);
                e_dir = 0;
            end else begin
                if (e_cnt == 0) upd_exp++;
                e_cnt = nxt_dn(e_cnt, rl);
                e_dir = 1;
            end
        end
        tick(4);
        chk(req, int'(count_o), e_cnt);
        chk("R8", int'(dir_o), e_dir);
    endtask

    initial begin
        int seed;
        int base;
        seed = $urandom(32'd7321);
        rst_n = 1'b0;
        tick(4);
        // R1: outputs idle while held in reset
        chk("R1", int'(count_o), 0);
        chk("R1", int'(dir_o), 0);
        chk("R1", int'(update_o), 0);
        rst_n = 1'b1;
        tick(3);
        chk("R1", int'(count_o), 0);

        // R2: free-running mode counts per clock while enabled
        reload_val = 8'd200;
        mode_sel = 4'd0;
        cnt_en = 1'b1;
        tick(9);
        cnt_en = 1'b0;
        chk("R2", int'(count_o), 9);
        tick(5);
        chk("R2", int'(count_o), 9);
        e_cnt = 9;

        // R2: unused code behaves as free-running
        mode_sel = 4'd13;
        cnt_en = 1'b1;
        tick(7);
        cnt_en = 1'b0;
        chk("R2", int'(count_o), 16);
        tick(3);
        chk("R2", int'(count_o), 16);

        // R9: rising trigger clears; then clock counting while enabled
        clear_cnt();
        chk("R9", int'(count_o), 0);
        chk("R9", upd_seen, upd_exp);
        cnt_en = 1'b1;
        tick(3);
        cnt_en = 1'b0;
        chk("R9", int'(count_o), 3);

        // R6: wrap up by the clock against a small reload
        clear_cnt();
        reload_val = 8'd3;
        mode_sel = 4'd0;
        cnt_en = 1'b1;
        tick(6);
        cnt_en = 1'b0;
        upd_exp++;
        chk("R6", int'(count_o), 2);
        chk("R6", upd_seen, upd_exp);
        reload_val = 8'd200;

        // R10: gated counting follows the trigger level, holds when low
        clear_cnt();
        mode_sel = 4'd5;
        cnt_en = 1'b1;
        tick(6);
        chk("R10", int'(count_o), 0);
        trig_in = 1'b1;
        tick(5);
        trig_in = 1'b0;
        tick(6);
        chk("R10", int'(count_o), 5);
        trig_in = 1'b1;
        tick(4);
        trig_in = 1'b0;
        tick(6);
        chk("R10", int'(count_o), 9);
        cnt_en = 1'b0;

        // R11: trigger start with enable low, falling trigger keeps it running
        clear_cnt();
        mode_sel = 4'd6;
        tick(3);
        chk("R11", int'(count_o), 0);
        trig_in = 1'b1;
        tick(5);
        chk("R11", int'(count_o), 2);
        trig_in = 1'b0;
        tick(5);
        chk("R11", int'(count_o), 7);
        mode_sel = 4'd0;
        tick(5);
        chk("R11", int'(count_o), 7);

        // R13: clear-and-start from a non-zero count with enable low
        mode_sel = 4'd8;
        tick(3);
        chk("R13", int'(count_o), 7);
        base = upd_seen;
        trig_in = 1'b1;
        tick(5);
        chk("R13", int'(count_o), 2);
        chk("R13", upd_seen - base, 1);
        trig_in = 1'b0;
        tick(3);
        chk("R13", int'(count_o), 5);
        mode_sel = 4'd0;
        upd_exp = upd_seen;

        // R12: one count per rising trigger while enabled
        clear_cnt();
        mode_sel = 4'd7;
        cnt_en = 1'b1;
        for (int k = 0; k < 5; k++) begin
            trig_in = 1'b1;
            tick(3);
            trig_in = 1'b0;
            tick(3);
        end
        tick(4);
        chk("R12", int'(count_o), 5);
        cnt_en = 1'b0;
        trig_in = 1'b1;
        tick(4);
        trig_in = 1'b0;
        tick(4);
        chk("R12", int'(count_o), 5);

        // R7, R6: directed wraps in x4 decoding
        clear_cnt();
        reload_val = 8'd9;
        mode_sel = 4'd3;
        cnt_en = 1'b1;
        enc_step(1'b0, 3, 9, "R7");
        chk("R7", upd_seen, upd_exp);
        enc_step(1'b1, 3, 9, "R6");
        chk("R6", upd_seen, upd_exp);

        // R5: full forward cycle is +4, full reverse is -4
        for (int k = 0; k < 4; k++) enc_step(1'b1, 3, 9, "R5");
        chk("R5", int'(count_o), 4);
        for (int k = 0; k < 4; k++) enc_step(1'b0, 3, 9, "R5");
        chk("R5", int'(count_o), 0);

        // R3, R4, R5: random walks per encoder mode with random reload
        for (int md = 1; md <= 3; md++) begin
            int rl;
            string tag;
            rl = 4 + int'($urandom % 20);
            tag = (md == 1) ? "R3" : (md == 2) ? "R4" : "R5";
            clear_cnt();
            reload_val = CNT_W'(rl);
            mode_sel = 4'(md);
            cnt_en = 1'b1;
            for (int s = 0; s < 60; s++) enc_step(bit'($urandom % 2), md, rl, tag);
            chk(tag, upd_seen, upd_exp);
            cnt_en = 1'b0;
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        wait (cyc >= WATCHDOG);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule